// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

One timer channel that watches a free-running main counter supplied from outside. Software reaches it through a small write/read port with two addresses. The first address holds the channel configuration. The second is a single comparator address. When the channel is enabled and the counter equals the stored match value, the channel sends out a one-cycle interrupt pulse. In periodic mode it also moves the match value forward by a stored period on that same cycle, so the pulses repeat at a fixed interval.

The comparator address writes into one of two internal registers. Which one it reaches depends on a load-match bit in the configuration register, and that bit clears itself. To arm periodic operation, software uses three writes:

1. A configuration write that sets the enable, periodic, wide and load-match bits.
2. A comparator write that carries the first match time, usually the current count plus the interval.
3. A second comparator write that carries the interval itself.

In one-shot mode a single comparator write sets the match value. The two comparator writes may come on consecutive cycles.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the configuration register reads 0, the comparator address reads 0, and `irq_o` is low.
- R2: A write to address 0 stores data bits [3:0] as enable (bit 0), periodic (bit 1), load-match (bit 2) and wide mode (bit 3). A read of address 0 returns those four bits, with all higher bits zero. The wide bit is only stored and read back.
- R3: A write to address 1 while load-match is set stores the data as the match value. Load-match then reads 0 from the next cycle on, with no further write.
- R4: A write to address 1 while load-match is clear and periodic is set stores the data as the period and leaves the match value unchanged. A read of address 1 always returns the match value.
- R5: A write to address 1 while load-match and periodic are both clear stores the data as the match value.
- R6: When enable is set and the counter equals the match value at a clock edge, `irq_o` is high for the cycle after that edge.
- R7: In periodic mode, a match adds the period to the match value on the same edge, modulo 2^DW, so the following pulses come every period counts.
- R8: In one-shot mode, a match leaves the match value unchanged. The next pulse comes only when the counter returns to that value.
- R9: While enable is clear, `irq_o` stays low, and comparator writes still load the match value and the period.
- R10: Two comparator writes on consecutive cycles load the match value and then the period, with no gap required.
- R11: If a comparator write to the match value lands on the same edge as a periodic reload, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | DW | Main counter value |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 1 | Register select: 0 configuration, 1 comparator |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Load-match self-clear.** A design that never clears the bit would send the second comparator write to the match value. The interval would be lost and the match time overwritten.
- **Back-to-back comparator writes.** A design that samples load-match late would send both writes to the same register.
- **Match and write on the same edge.** A design that lets the reload win would move the match away from the time software just wrote.
- **Period wrap.** Reloads must wrap modulo 2^DW.
- **Disabled and one-shot channels.** A disabled channel that still fires, or a one-shot channel that changes its match value, shows up as an extra or missing pulse against the model.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam logic A_CFG = 1'b0;
  localparam logic A_CMP = 1'b1;

  logic          en_q, per_q, ld_q, wide_q;
  logic [DW-1:0] match_q, period_q;

  wire cfg_wr = wr_i && (addr_i == A_CFG);
  wire cmp_wr = wr_i && (addr_i == A_CMP);
  wire fire   = en_q && (cnt_i == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      ld_q     <= 1'b0;
      wide_q   <= 1'b0;
      match_q  <= '0;
      period_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= fire;
      if (fire && per_q)
        match_q <= match_q + period_q;
      if (cfg_wr)
        {wide_q, ld_q, per_q, en_q} <= wdata_i[3:0];
      if (cmp_wr) begin
        if (ld_q) begin
          match_q <= wdata_i;
          ld_q    <= 1'b0;
        end else if (per_q) begin
          period_q <= wdata_i;
        end else begin
          match_q <= wdata_i;
        end
      end
    end
  end

  assign rdata_o = (addr_i == A_CFG) ? {{(DW-4){1'b0}}, wide_q, ld_q, per_q, en_q} : match_q;

  // R3
  ld_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && ld_q) |=> (!ld_q && match_q == $past(wdata_i)));

  // R4
  per_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !ld_q && per_q && !fire) |=> (match_q == $past(match_q)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_q && !cmp_wr) |=> (match_q == DW'($past(match_q) + $past(period_q))));

  // R8
  oneshot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per_q && !cmp_wr) |=> $stable(match_q));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_o);
endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] cnt = '0;
  logic wr = 1'b0;
  logic addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  int n_irq = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_chan #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) cnt <= cnt + 1;

  logic m_en = 0, m_per = 0, m_ld = 0, m_wide = 0, m_irq = 0;
  logic [DW-1:0] m_match = '0, m_period = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 0; m_per <= 0; m_ld <= 0; m_wide <= 0; m_irq <= 0;
      m_match <= '0; m_period <= '0;
    end else begin
      m_irq <= m_en && (cnt == m_match);
      if (m_en && m_per && cnt == m_match) m_match <= m_match + m_period;
      if (wr && !addr) {m_wide, m_ld, m_per, m_en} <= wdata[3:0];
      if (wr && addr) begin
        if (m_ld) begin m_match <= wdata; m_ld <= 0; end
        else if (m_per) m_period <= wdata;
        else m_match <= wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(irq === m_irq, "R6/R7/R8/R9 irq", {31'b0, irq}, {31'b0, m_irq});
    if (irq) n_irq++;
  end

  task automatic wr1(input logic a, input logic [DW-1:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd(input logic a, input logic [DW-1:0] exp, input string tag);
    addr = a; #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] m;
    process::self().srandom(32'd7);
    idle(3);
    rd(0, '0, "R1 cfg");
    rd(1, '0, "R1 cmp");
    chk(irq === 1'b0, "R1 irq", {31'b0, irq}, '0);
    rst_n = 1;
    @(negedge clk);

    // R2 field readback
    wr1(0, 32'h0000_00FA);
    rd(0, 32'hA, "R2 cfg bits");
    wr1(0, 32'h0);
    rd(0, 32'h0, "R2 cfg clear");

    // R5 one-shot load, R9 disabled quiet
    m = cnt + 6;
    wr1(1, m);
    rd(1, m, "R5 oneshot load");
    n_irq = 0; idle(12);
    chk(n_irq == 0, "R9 no irq when off", n_irq, 0);

    // R3/R4 periodic programming, disabled first
    wr1(0, 32'h6);
    rd(0, 32'h6, "R2 ld set");
    wr1(1, 32'h1234);
    rd(0, 32'h2, "R3 ld self-clear");
    rd(1, 32'h1234, "R3 match load");
    wr1(1, 32'h10);
    rd(1, 32'h1234, "R4 match kept");

    // R10 back-to-back, enabled periodic; R7 spacing
    wr1(0, 32'hF);
    m = cnt + 8;
    wr = 1; addr = 1; wdata = m;
    @(negedge clk);
    wdata = 32'd5;
    @(negedge clk);
    wr = 0;
    rd(1, m, "R10 match after b2b");
    n_irq = 0; idle(28);
    chk(n_irq == 5, "R10/R7 pulse count", n_irq, 5);

    // R8 one-shot keeps match
    wr1(0, 32'h1);
    m = cnt + 5;
    wr1(1, m);
    idle(10);
    rd(1, m, "R8 oneshot match kept");

    // R11 write beats reload
    wr1(0, 32'h7);
    m = cnt + 10;
    wr1(1, m);
    wr1(1, 32'd3);
    wr1(0, 32'h7);
    while (cnt != m) @(negedge clk);
    wr1(1, 32'h0BAD_0000);
    rd(1, 32'h0BAD_0000, "R11 write wins");

    // R7 wrap modulo 2^DW
    wr1(0, 32'h7);
    m = cnt + 6;
    wr1(1, m);
    wr1(1, 32'hFFFF_FFFE);
    while (cnt != m + 1) @(negedge clk);
    rd(1, m - 2, "R7 wrap");

    // random
    for (int it = 0; it < 80; it++) begin
      logic per, en, b2b;
      logic [DW-1:0] d;
      per = $urandom_range(0, 1);
      en  = ($urandom_range(0, 3) != 0);
      b2b = $urandom_range(0, 1);
      d   = $urandom_range(1, 40);
      if (per) begin
        wr1(0, {28'b0, 1'b1, 1'b1, 1'b1, en});
        wr = 1; addr = 1; wdata = cnt + d;
        @(negedge clk);
        if (!b2b) begin wr = 0; @(negedge clk); wr = 1; end
        wdata = d;
        @(negedge clk);
        wr = 0;
      end else begin
        wr1(0, {28'b0, 1'b1, 1'b0, 1'b0, en});
        wr1(1, cnt + d);
      end
      idle(3 * int'(d) + 4);
      rd(1, m_match, "R3/R4/R5/R7 random match");
      rd(0, {28'b0, m_wide, m_ld, m_per, m_en}, "R2/R3 random cfg");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule